// File: doc/BRIEF.md
# I2C Master SCL Half-Period Pacer

This block produces the serial clock of an I2C master. A programmable reload value sets the length of each half-period: the counter loads that value and counts down to zero. The zero count marks a rollover, which flips the internal clock phase. During a low phase the block pulls SCL low. During a high phase it lets SCL go.

After the block releases SCL it does not start timing the high phase at once. It first waits until the real bus line, brought through a two-flop synchronizer, reads high. Only then does it reload and count. A slave or another master that holds SCL low therefore stretches the clock, and the high time on the bus is never shorter than one full count.

A reload value below two is rejected. The block then raises a flag and leaves SCL released. Dropping the run enable returns the block to idle on the next edge. The byte engine around the block uses the rollover pulse to step its own sequencing.

Top module: `scl_pacer`

## Requirements
- R1: After reset, and with run_en low, scl_drive_low is 0 (SCL released), half_tick is 0 and bad_reload is 0 when reload_val is 2 or more.
- R2: Starting from idle, asserting run_en with a legal reload value L makes scl_drive_low 1 (1 means pull SCL low) on the next cycle. The output stays 1 for exactly L+1 cycles.
- R3: When a count reaches zero, half_tick is 1 for one cycle, and in that same cycle the phase toggles between low (scl_drive_low=1) and high (scl_drive_low=0).
- R4: After a low phase ends, counting is suspended while the synchronized SCL reads low. No half_tick occurs during this wait, however long the line is held.
- R5: The first cycle in which the synchronized SCL reads high reloads the counter with L. With no external hold, the released phase therefore lasts L+4 cycles: 3 cycles of synchronizer and wait, then L+1 counted cycles.
- R6: reload_val values 0 and 1 are illegal. In the cycle after one is presented, bad_reload is 1, SCL is released and no half_tick is produced.
- R7: Deasserting run_en releases SCL and stops ticks from the next cycle on, and clears the count. A later enable gives a full L+1 low phase again.
- R8: The raw SCL input passes through a two-flop synchronizer that resets to the released (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run request; low forces idle |
| reload_val | input | CNT_W | Half-period reload value, legal from 2 |
| scl_in | input | 1 | Raw level read from the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| half_tick | output | 1 | One-cycle pulse on each half-period rollover |
| bad_reload | output | 1 | Reload value is illegal (below 2) |

## Verification
All outputs are registered, so a change of run_en or reload_val shows on the outputs one edge later. A release of SCL reaches the reload decision three edges later, through two synchronizer flops and then the state update. The bench keeps a behavioural reference model that takes the line level read just before each rising edge and forecasts every output for that edge. It compares at the following falling edge, so each check lands in the cycle the result is due. Directed measurements of low width, unstretched high width and tick silence during a hold then test the L+1 and L+4 figures directly.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HWAIT = 2'd2,
    ST_HIGH  = 2'd3
  } pace_state_t;

  localparam int unsigned MIN_LEGAL_RELOAD = 2;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic synced
);
  logic [STAGES-1:0] flop_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flop_q[g] <= 1'b1;
          else        flop_q[g] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flop_q[g] <= 1'b1;
          else        flop_q[g] <= flop_q[g-1];
        end
      end
    end
  endgenerate

  assign synced = flop_q[STAGES-1];
endmodule

// File: rtl/half_period_counter.sv
module half_period_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | load | dec;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             half_tick,
  output logic             bad_reload
);
  localparam logic [CNT_W-1:0] MIN_RL = CNT_W'(MIN_LEGAL_RELOAD);

  pace_state_t      st_q, st_d;
  logic             tick_q, tick_d;
  logic             bad_q, bad_d;
  logic             scl_hi;
  logic             legal;
  logic             c_clr, c_load, c_dec, c_zero;
  logic [CNT_W-1:0] cnt_q;

  scl_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (scl_in),
    .synced (scl_hi)
  );

  half_period_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (c_clr),
    .load     (c_load),
    .dec      (c_dec),
    .load_val (reload_val),
    .count    (cnt_q),
    .at_zero  (c_zero)
  );

  assign legal = (reload_val >= MIN_RL);

  always_comb begin
    st_d   = st_q;
    tick_d = 1'b0;
    c_clr  = 1'b0;
    c_load = 1'b0;
    c_dec  = 1'b0;
    bad_d  = !legal;
    if (!run_en || !legal) begin
      st_d  = ST_IDLE;
      c_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d   = ST_LOW;
          c_load = 1'b1;
        end
        ST_LOW: begin
          if (c_zero) begin
            st_d   = ST_HWAIT;
            tick_d = 1'b1;
          end else begin
            c_dec = 1'b1;
          end
        end
        ST_HWAIT: begin
          if (scl_hi) begin
            st_d   = ST_HIGH;
            c_load = 1'b1;
          end
        end
        ST_HIGH: begin
          if (c_zero) begin
            st_d   = ST_LOW;
            c_load = 1'b1;
            tick_d = 1'b1;
          end else begin
            c_dec = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tick_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tick_q <= tick_d;
      bad_q  <= bad_d;
    end
  end

  assign scl_drive_low = (st_q == ST_LOW);
  assign half_tick     = tick_q;
  assign bad_reload    = bad_q;
endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk
  import scl_pacer_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic [CNT_W-1:0] reload_val,
  input logic             scl_drive_low,
  input logic             half_tick,
  input logic             bad_reload,
  input pace_state_t      st,
  input logic [CNT_W-1:0] cnt,
  input logic             scl_hi
);
  logic go;
  assign go = run_en && (reload_val >= CNT_W'(MIN_LEGAL_RELOAD));

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!scl_drive_low && !half_tick));

  // R6
  bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_reload |-> (!scl_drive_low && !half_tick));

  // R4
  stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HWAIT && !scl_hi && go) |=> (st == ST_HWAIT && $stable(cnt) && !half_tick));

  // R5
  reload_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HWAIT && scl_hi && go) |=> (st == ST_HIGH && cnt == $past(reload_val)));

  // R3
  low_rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW && cnt == '0 && go) |=> (half_tick && !scl_drive_low));
endmodule

bind scl_pacer scl_pacer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_en        (run_en),
  .reload_val    (reload_val),
  .scl_drive_low (scl_drive_low),
  .half_tick     (half_tick),
  .bad_reload    (bad_reload),
  .st            (st_q),
  .cnt           (cnt_q),
  .scl_hi        (scl_hi)
);

// File: tb/test_scl_pacer.sv
`timescale 1ns/1ps
module test_scl_pacer;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             run_en;
  logic [CNT_W-1:0] reload_val;
  logic             hold_low;
  logic             scl_in;
  logic             scl_drive_low, half_tick, bad_reload;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // model state (behavioural)
  int m_act, m_low, m_wait, m_cnt, m_tick, m_bad, m_s1, m_s2;

  always #10 clk = ~clk;

  assign scl_in = ~(scl_drive_low | hold_low);

  scl_pacer #(.CNT_W(CNT_W)) i_scl_pacer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload_val(reload_val),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .half_tick(half_tick),
    .bad_reload(bad_reload)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input int line);
    int sy;
    int rl;
    sy = m_s2; m_s2 = m_s1; m_s1 = line;
    rl = int'(reload_val);
    m_tick = 0;
    if (!run_en || rl < 2) begin
      m_act = 0; m_low = 0; m_wait = 0; m_cnt = 0;
    end else if (!m_act) begin
      m_act = 1; m_low = 1; m_wait = 0; m_cnt = rl;
    end else if (m_wait) begin
      if (sy != 0) begin m_wait = 0; m_cnt = rl; end
    end else if (m_cnt == 0) begin
      m_tick = 1;
      if (m_low) begin m_low = 0; m_wait = 1; end
      else begin m_low = 1; m_cnt = rl; end
    end else begin
      m_cnt--;
    end
    m_bad = (rl < 2);
  endtask

  // one clock: sample line, pass edge, update model, compare at negedge
  task automatic step();
    int line;
    #1 line = int'(scl_in);
    @(posedge clk);
    @(negedge clk);
    model_edge(line);
    chk(scl_drive_low == (m_act && m_low), "R2/R3", "scl_drive_low", scl_drive_low, m_act && m_low);
    chk(half_tick == m_tick, "R3/R4", "half_tick", half_tick, m_tick);
    chk(bad_reload == m_bad, "R6", "bad_reload", bad_reload, m_bad);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int w, t;
    rst_n = 1'b0; run_en = 1'b0; reload_val = CNT_W'(3); hold_low = 1'b0;
    m_act = 0; m_low = 0; m_wait = 0; m_cnt = 0; m_tick = 0; m_bad = 0; m_s1 = 1; m_s2 = 1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(scl_drive_low == 1'b0, "R1", "reset drive", scl_drive_low, 0);
    chk(half_tick == 1'b0, "R1", "reset tick", half_tick, 0);
    chk(bad_reload == 1'b0, "R1", "reset bad", bad_reload, 0);
    rst_n = 1'b1;
    run(3);

    // R2: low width L+1 with L=3
    run_en = 1'b1;
    step();
    w = 0;
    while (scl_drive_low && w < 50) begin w++; step(); end
    chk(w == 4, "R2", "low width L=3", w, 4);
    // R5: released width L+4 with no hold
    w = 0;
    while (!scl_drive_low && w < 50) begin w++; step(); end
    chk(w == 7, "R5", "high width L=3", w, 7);
    run(30);

    // R4: hold SCL low after release, no ticks during hold
    while (!scl_drive_low) step();
    hold_low = 1'b1;
    while (scl_drive_low) step();
    t = 0;
    for (int i = 0; i < 12; i++) begin step(); t += int'(half_tick); end
    chk(t == 0, "R4", "ticks during hold", t, 0);
    hold_low = 1'b0;
    w = 0;
    while (!scl_drive_low && w < 50) begin w++; step(); end
    chk(w == 7, "R5", "high after hold ends", w, 7);

    // R7: disable mid low phase, then restart gets full low phase
    run(2);
    run_en = 1'b0;
    step();
    chk(scl_drive_low == 1'b0, "R7", "released after disable", scl_drive_low, 0);
    run(4);
    reload_val = CNT_W'(9);
    run_en = 1'b1;
    step();
    w = 0;
    while (scl_drive_low && w < 50) begin w++; step(); end
    chk(w == 10, "R7", "full low width L=9 after restart", w, 10);
    run(60);

    // R6: illegal reload 1 and 0
    reload_val = CNT_W'(1);
    step();
    chk(bad_reload == 1'b1, "R6", "flag for reload 1", bad_reload, 1);
    run(10);
    reload_val = CNT_W'(0);
    run(10);
    chk(scl_drive_low == 1'b0, "R6", "released for reload 0", scl_drive_low, 0);

    // R8: smallest legal value, synchronizer latency covered by model compare
    reload_val = CNT_W'(2);
    run(40);
    run_en = 1'b0;
    run(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule